// File: doc/BRIEF.md
# Two-Phase Interleaved PWM Timing Generator

This block produces the switching requests for a two-phase step-down regulator from one clock. A single period counter sets the switching period. The second phase runs from the same count, delayed by half a period, so the two phases turn on alternately. For each phase the block takes a digitized comparator input. That input goes high once the summed control signal of the phase has crossed its ramp. From it the block drives a high-side request, a complementary low-side request and a one-clock ramp-reset strobe.

Two limits are applied in every period. The high-side request is cut off at a fixed share of the period, which caps the duty cycle at about 90%. A guaranteed low-side window is also reserved at the end of each period. Its length is the larger of 10% of the period (rounded down) and a programmed minimum, both counted in clock cycles. The period and the minimum are captured while the block is disabled, and again on the edge that starts it. They then stay fixed until the enable is dropped.

The block has no streaming data path. All pins are plain control or status levels, so no valid/ready handshake or back-pressure applies.

Top module: `pwm2_interleave`

## Requirements
- R1: While `enable` is low, and from the first cycle after `enable` is sampled low, every bit of `hs_req`, `ls_req` and `ramp_rst` is 0.
- R2: The first cycle after `enable` is first sampled high is position 0 of a phase-0 period. `ramp_rst[0]` is a one-cycle pulse at position 0 of every phase-0 period, which repeats every P cycles, where P is the captured period.
- R3: Phase 1 starts floor(P/2) cycles after each phase-0 start, which rounds an odd P down. `ramp_rst[1]` pulses at each phase-1 start. Phase 1 stays idle, with all outputs 0, until its first start after enable.
- R4: The high-side request of a phase is 1 at position 0 when its comparator input is low. It drops in the same cycle its comparator input is high. Once low, it stays low until the next start of that phase.
- R5: The low-side window lasts L = max(floor(P*10/100), M) cycles, where M is the captured minimum low-side time. The high-side request of a phase is 0 at every position ≥ P−L, whether or not the comparator has tripped.
- R6: When L ≥ P, the high-side request never asserts.
- R7: For an active phase, `ls_req` is the inverse of `hs_req`. The two are never 1 together.
- R8: A `period_cyc` value of 0 or 1 is treated as a period of 2.
- R9: Changing `period_cyc` or `min_low_cyc` while enabled has no effect on the running timing. The values are captured only while disabled and at the enabling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the generator when high |
| period_cyc | input | CNT_W | Switching period in clock cycles |
| min_low_cyc | input | CNT_W | Minimum low-side window in cycles |
| cmp_trip | input | 2 | Per phase: control signal has crossed its ramp |
| hs_req | output | 2 | Per phase high-side on request |
| ls_req | output | 2 | Per phase low-side on request |
| ramp_rst | output | 2 | Per phase one-cycle ramp restart strobe |

## Verification
The bench builds the block with its defaults: a 16-bit count width and a 10% low-side share. It then programs short periods of 1 to 100 cycles, so that every timing regime fits within a few hundred cycles. These regimes are an odd period with a rounded-down phase offset, the clamped two-cycle period, a window set by the programmed floor and one set by the percentage, and a floor longer than the period. Comparator patterns cover tripping at fixed positions, never tripping and pseudo-random trips. One run also changes the period mid-run to show that the captured value holds.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;
  localparam int unsigned NPHASE    = 2;
  localparam int unsigned PCT_SCALE = 100;
  localparam int unsigned MIN_PER   = 2;
endpackage

// File: rtl/pwm2_timebase.sv
module pwm2_timebase
  import pwm2_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned LOW_PCT = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] period_cyc,
  input  logic [CNT_W-1:0] min_low_cyc,
  output logic [NPHASE-1:0] active,
  output logic [CNT_W-1:0] pos0,
  output logic [CNT_W-1:0] pos1,
  output logic [CNT_W-1:0] half,
  output logic [CNT_W-1:0] lim
);
  localparam int unsigned PROD_W = CNT_W + 8;

  logic             run_q;
  logic             act1_q;
  logic [CNT_W-1:0] pos_q;
  logic [CNT_W-1:0] per_q;
  logic [CNT_W-1:0] mlow_q;
  logic [CNT_W-1:0] per_in;
  logic [PROD_W-1:0] prod;
  logic [CNT_W-1:0] pct_low;
  logic [CNT_W-1:0] low_len;
  logic             at_half;
  logic             at_end;

  // period values below the minimum are clamped
  always_comb begin
    if (period_cyc < CNT_W'(MIN_PER)) per_in = CNT_W'(MIN_PER);
    else                              per_in = period_cyc;
  end

  assign half    = per_q >> 1;
  assign at_half = (pos_q == half);
  assign at_end  = (pos_q == per_q - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      act1_q <= 1'b0;
      pos_q  <= '0;
      per_q  <= CNT_W'(MIN_PER);
      mlow_q <= '0;
    end else if (!enable || !run_q) begin
      run_q  <= enable;
      act1_q <= 1'b0;
      pos_q  <= '0;
      per_q  <= per_in;
      mlow_q <= min_low_cyc;
    end else begin
      pos_q <= at_end ? '0 : pos_q + CNT_W'(1);
      if (at_half) act1_q <= 1'b1;
    end
  end

  // guaranteed low-side window: larger of share of period and floor
  assign prod    = PROD_W'(per_q) * PROD_W'(LOW_PCT);
  assign pct_low = CNT_W'(prod / PROD_W'(PCT_SCALE));
  assign low_len = (pct_low > mlow_q) ? pct_low : mlow_q;
  assign lim     = (low_len >= per_q) ? '0 : per_q - low_len;

  assign pos0 = pos_q;
  assign pos1 = (pos_q >= half) ? pos_q - half : pos_q + (per_q - half);

  assign active[0] = run_q;
  assign active[1] = run_q & (act1_q | at_half);
endmodule

// File: rtl/pwm2_phase.sv
module pwm2_phase #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [CNT_W-1:0] pos,
  input  logic [CNT_W-1:0] lim,
  input  logic             trip,
  output logic             hs_req,
  output logic             ls_req,
  output logic             ramp_rst
);
  logic off_q;
  logic start;
  logic in_win;

  assign start  = active & (pos == '0);
  assign in_win = (pos < lim);
  assign hs_req = active & in_win & ~trip & (start | ~off_q);
  assign ls_req = active & ~hs_req;
  assign ramp_rst = start;

  // once the high side is off it stays off until the next start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) off_q <= 1'b1;
    else        off_q <= ~hs_req;
  end
endmodule

// File: rtl/pwm2_interleave.sv
module pwm2_interleave
  import pwm2_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned LOW_PCT = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] period_cyc,
  input  logic [CNT_W-1:0] min_low_cyc,
  input  logic [1:0]       cmp_trip,
  output logic [1:0]       hs_req,
  output logic [1:0]       ls_req,
  output logic [1:0]       ramp_rst
);
  logic [NPHASE-1:0] active;
  logic [CNT_W-1:0]  pos0;
  logic [CNT_W-1:0]  pos1;
  logic [CNT_W-1:0]  half;
  logic [CNT_W-1:0]  lim;
  logic [CNT_W-1:0]  pos_arr [NPHASE];

  pwm2_timebase #(.CNT_W(CNT_W), .LOW_PCT(LOW_PCT)) u_tb (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .period_cyc(period_cyc), .min_low_cyc(min_low_cyc),
    .active(active), .pos0(pos0), .pos1(pos1), .half(half), .lim(lim)
  );

  assign pos_arr[0] = pos0;
  assign pos_arr[1] = pos1;

  for (genvar g = 0; g < NPHASE; g++) begin : g_ph
    pwm2_phase #(.CNT_W(CNT_W)) u_ph (
      .clk(clk), .rst_n(rst_n), .active(active[g]),
      .pos(pos_arr[g]), .lim(lim), .trip(cmp_trip[g]),
      .hs_req(hs_req[g]), .ls_req(ls_req[g]), .ramp_rst(ramp_rst[g])
    );
  end
endmodule

// File: rtl/pwm2_interleave_chk.sv
module pwm2_interleave_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [1:0]       hs_req,
  input logic [1:0]       ls_req,
  input logic [1:0]       ramp_rst,
  input logic [CNT_W-1:0] lim,
  input logic [CNT_W-1:0] half
);
  logic [CNT_W:0] since [2];
  logic [1:0]     seen;
  logic [CNT_W:0] cpos  [2];

  for (genvar g = 0; g < 2; g++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        since[g] <= '0;
        seen[g]  <= 1'b0;
      end else if (!enable) begin
        seen[g]  <= 1'b0;
      end else if (ramp_rst[g]) begin
        since[g] <= (CNT_W+1)'(1);
        seen[g]  <= 1'b1;
      end else if (since[g] != {(CNT_W+1){1'b1}}) begin
        since[g] <= since[g] + (CNT_W+1)'(1);
      end
    end
    assign cpos[g] = ramp_rst[g] ? '0 : since[g];

    // R2: ramp strobe lasts one cycle
    p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ramp_rst[g] |=> !ramp_rst[g]);
    // R4: after dropping, high side only returns at a period start
    p_latch_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !hs_req[g] |=> (!hs_req[g] || ramp_rst[g]));
    // R5: high side stays out of the low-side window
    p_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hs_req[g] |-> ((seen[g] || ramp_rst[g]) && (cpos[g] < {1'b0, lim})));
  end

  // R1: disabled block drives nothing
  p_idle_outputs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (hs_req == 2'b00 && ls_req == 2'b00 && ramp_rst == 2'b00));
  // R3: phase 1 starts half a period after phase 0
  p_gap_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_rst[1] |-> (seen[0] && cpos[0] == {1'b0, half}));
  // R7: high and low requests are exclusive
  p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_req & ls_req) == 2'b00);
endmodule

bind pwm2_interleave pwm2_interleave_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable),
  .hs_req(hs_req), .ls_req(ls_req), .ramp_rst(ramp_rst),
  .lim(lim), .half(half)
);

// File: tb/pwm2_interleave_tb.sv
module pwm2_interleave_tb;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [W-1:0] period_cyc = 20;
  logic [W-1:0] min_low_cyc = 3;
  logic [1:0] cmp_trip = 2'b00;
  logic [1:0] hs_req, ls_req, ramp_rst;

  always #2 clk = ~clk;

  pwm2_interleave #(.CNT_W(W), .LOW_PCT(10)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .period_cyc(period_cyc), .min_low_cyc(min_low_cyc),
    .cmp_trip(cmp_trip), .hs_req(hs_req), .ls_req(ls_req), .ramp_rst(ramp_rst)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // reference model: t = cycles since start of running, -1 when idle
  int t = -1;
  int mP = 2;
  int mM = 0;
  bit mdone [2] = '{1'b1, 1'b1};
  bit e_hs [2];
  bit e_ls [2];
  bit e_rr [2];
  bit e_ok [2];
  int e_pos [2];
  int e_lim;

  function void eval();
    int low;
    low = (mP * 10) / 100;
    if (mM > low) low = mM;
    e_lim = (low >= mP) ? 0 : mP - low;
    for (int ph = 0; ph < 2; ph++) begin
      if (t < 0) begin
        e_ok[ph] = 0; e_pos[ph] = 0;
      end else if (ph == 0) begin
        e_ok[ph] = 1; e_pos[ph] = t % mP;
      end else begin
        e_ok[ph] = (t >= mP / 2);
        e_pos[ph] = e_ok[ph] ? (t - mP / 2) % mP : 0;
      end
      e_rr[ph] = e_ok[ph] && e_pos[ph] == 0;
      e_hs[ph] = e_ok[ph] && e_pos[ph] < e_lim && !cmp_trip[ph] && (e_rr[ph] || !mdone[ph]);
      e_ls[ph] = e_ok[ph] && !e_hs[ph];
    end
  endfunction

  function int clampP(int p);
    return (p < 2) ? 2 : p;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      t = -1;
      mdone[0] = 1; mdone[1] = 1;
    end else begin
      eval();
      mdone[0] = !e_hs[0];
      mdone[1] = !e_hs[1];
      if (!enable) begin
        t = -1; mP = clampP(int'(period_cyc)); mM = int'(min_low_cyc);
      end else if (t < 0) begin
        t = 0; mP = clampP(int'(period_cyc)); mM = int'(min_low_cyc);
      end else begin
        t = t + 1;
      end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // measurement state
  int cyc = 0;
  int last0 = -1;
  int int0 = -1;
  int gap = -1;
  int hs_cnt = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      string tg;
      eval();
      for (int ph = 0; ph < 2; ph++) begin
        if (t < 0) tg = "R1";
        else if (ph == 0) tg = "R2";
        else tg = "R3";
        chk(ramp_rst[ph] == e_rr[ph], tg, $sformatf("ramp_rst[%0d]", ph), ramp_rst[ph], e_rr[ph]);
        if (t < 0) tg = "R1";
        else if (!e_ok[ph]) tg = "R3";
        else if (e_lim == 0) tg = "R6";
        else if (e_pos[ph] >= e_lim) tg = "R5";
        else tg = "R4";
        chk(hs_req[ph] == e_hs[ph], tg, $sformatf("hs_req[%0d]", ph), hs_req[ph], e_hs[ph]);
        tg = (t < 0) ? "R1" : "R7";
        chk(ls_req[ph] == e_ls[ph], tg, $sformatf("ls_req[%0d]", ph), ls_req[ph], e_ls[ph]);
      end
      if (!enable) last0 = -1;
      if (ramp_rst[0]) begin
        if (last0 >= 0) int0 = cyc - last0;
        last0 = cyc;
      end
      if (ramp_rst[1] && last0 >= 0) gap = cyc - last0;
      if (|hs_req) hs_cnt++;
    end
  end

  // comparator stimulus
  int mode = 0;
  int k [2] = '{5, 9};

  task automatic step(int n);
    repeat (n) begin
      @(posedge clk);
      #1;
      for (int ph = 0; ph < 2; ph++) begin
        int p;
        if (t < 0) p = 0;
        else if (ph == 0) p = t % mP;
        else p = (t >= mP / 2) ? (t - mP / 2) % mP : 0;
        case (mode)
          1: cmp_trip[ph] = (p >= k[ph]);
          2: cmp_trip[ph] = ($urandom_range(0, 3) == 0);
          default: cmp_trip[ph] = 1'b0;
        endcase
      end
    end
  endtask

  task automatic start_run(int p, int m, int md);
    enable = 1'b0;
    step(3);
    period_cyc = W'(p);
    min_low_cyc = W'(m);
    mode = md;
    step(1);
    hs_cnt = 0;
    int0 = -1;
    gap = -1;
    enable = 1'b1;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hs_req == 0 && ls_req == 0 && ramp_rst == 0, "R1", "outputs after reset",
        {hs_req, ls_req, ramp_rst}, 0);

    // trips at fixed positions, floor-dominated window
    start_run(20, 3, 1);
    step(100);
    @(negedge clk);
    chk(int0 == 20, "R2", "phase0 period", int0, 20);
    chk(gap == 10, "R3", "phase1 offset", gap, 10);

    // R9: running settings frozen
    period_cyc = 50;
    min_low_cyc = 40;
    step(60);
    @(negedge clk);
    chk(int0 == 20, "R9", "period after live change", int0, 20);

    // R5: comparator never trips, percentage window ends high side
    start_run(100, 2, 0);
    step(250);

    // odd period, random trips
    start_run(21, 0, 2);
    step(120);
    @(negedge clk);
    chk(gap == 10, "R3", "odd period offset", gap, 10);

    // R6: floor longer than period
    start_run(10, 12, 0);
    step(50);
    @(negedge clk);
    chk(hs_cnt == 0, "R6", "high-side cycles", hs_cnt, 0);

    // R8: clamped period
    start_run(1, 0, 0);
    step(20);
    @(negedge clk);
    chk(int0 == 2, "R8", "clamped period", int0, 2);

    enable = 1'b0;
    step(4);
    @(negedge clk);
    chk(hs_req == 0 && ls_req == 0 && ramp_rst == 0, "R1", "outputs after disable",
        {hs_req, ls_req, ramp_rst}, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule